// File: doc/BRIEF.md
# Two-Band Oscillator Band Selector

This block is a small sequencing state machine that runs once, before fine frequency acquisition, to decide which of two oscillator frequency bands a clock recovery loop should use. When enabled, it selects the upper band and commands the analog side to hold the oscillator control voltage at the bottom of that band. It then watches the frequency detector's UP indication for a programmable number of settle ticks. An incoming rate above the slowest upper-band frequency produces UP, and the block keeps the upper band. With no UP in the window, it falls back to the lower band.

Whichever band it picks, it then commands the control voltage to the top of that band. It waits a fixed number of settle ticks for the analog side to follow, then raises a done flag and releases the voltage command so the frequency detector can pull the loop in from there. Dropping enable abandons the sequence at once and clears done. The band bit keeps its last value until the next run.

Settle ticks come from a slower timer outside the block and are single-cycle pulses in the block's clock domain.

Top module: `vco_band_picker`

## Requirements
- R1: While reset is held and after its release with enable low, done is 0, the voltage command `vforce` is 2'b00 (released) and `band_sel` is 1 (1 = upper band, 0 = lower band).
- R2: One cycle after enable is sampled high while idle, `band_sel` is 1 and `vforce` is 2'b01 (hold at band minimum).
- R3: The observation window ends on the clock edge that samples the `win_ticks`-th settle tick counted while observing, and a `win_ticks` value of 0 acts as 1. Until that edge, `vforce` stays 2'b01.
- R4: If UP is high in any cycle of the observation window, including the cycle of the final tick, then after the window `band_sel` is 1 and `vforce` is 2'b10 (hold at band maximum).
- R5: If UP is never high during the window, then after the window `band_sel` is 0 and `vforce` is 2'b10.
- R6: UP has no effect on `band_sel` while idle, while parked at the maximum, or while done.
- R7: After `PARK_TICKS` settle ticks at the maximum, done becomes 1 and `vforce` returns to 2'b00. Both hold while enable stays high.
- R8: One cycle after enable is sampled low in any state, done is 0 and `vforce` is 2'b00, while `band_sel` keeps its value. A later enable restarts from R2.
- R9: Settle ticks that arrive while idle are not counted toward the observation window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Starts the search when high; abort and idle when low |
| up_in | input | 1 | UP indication from the frequency detector |
| settle_tick | input | 1 | Single-cycle pulse from the settle timer |
| win_ticks | input | CNT_W | Observation window length in settle ticks (0 acts as 1) |
| band_sel | output | 1 | Band control bit to the oscillator (1 = upper band) |
| vforce | output | 2 | Voltage command: 00 release, 01 hold at minimum, 10 hold at maximum |
| done | output | 1 | Band chosen and voltage released |

## Verification
The bench places UP at the edges of the observation window. It puts one pulse early in the window, one on the same cycle as the final tick, and some only after the window has closed. A design that drops the final-cycle pulse would pick the lower band. One that listens past the window would flip to the upper band late. The bench also sends ticks while idle and sets a zero window length. A design that counted idle ticks would close the window early, and one that took zero literally would wait through a full counter wrap. Enable is dropped during parking, during observation and after done. Each of those cases must release the voltage, clear done and keep the band bit, and a design that reset the band bit on abort would show the wrong band.

// File: rtl/bsel_pkg.sv
// Shared types for the oscillator band selector.
// Assumes: vforce encoding 2'b11 is never driven.
package bsel_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_OBSERVE = 2'd1,
        ST_PARK    = 2'd2,
        ST_DONE    = 2'd3
    } bsel_state_e;

    typedef enum logic [1:0] {
        VF_RELEASE = 2'b00,
        VF_MIN     = 2'b01,
        VF_MAX     = 2'b10
    } vforce_e;

    localparam logic BAND_LOW  = 1'b0;
    localparam logic BAND_HIGH = 1'b1;

endpackage

// File: rtl/bsel_tick_window.sv
// Counts settle ticks while run is high and pulses expire, combinationally,
// on the cycle that carries the limit-th tick.
// Assumes: limit of 0 behaves as 1; limit held steady while run is high.
module bsel_tick_window #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         expire
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt;
    logic [W-1:0] limit_eff;
    logic         last;

    // Effective limit and last-tick detection.
    always_comb begin
        limit_eff = (limit == '0) ? ONE : limit;
        last      = (cnt >= (limit_eff - ONE));
        expire    = run && tick && last;
    end

    // Tick counter: cleared when not running or on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (!run)     cnt <= '0;
        else if (tick)     cnt <= last ? '0 : cnt + ONE;
    end

    // Counter is idle at zero whenever the window is not running (R9).
    assert_idle_count_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0) || run);

    // A non-final tick while running advances the count by one (R3).
    assert_count_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !expire) |=> (cnt == $past(cnt) + ONE));

endmodule

// File: rtl/bsel_up_capture.sv
// Sticky capture of the UP indication during the observation window.
// seen includes the current cycle so a pulse on the final cycle counts.
// Assumes: arm is high exactly for the observation state.
module bsel_up_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic up_in,
    output logic seen
);
    logic seen_q;

    // Registered flag: set by UP while armed, cleared while disarmed.
    always_ff @(posedge clk) begin
        if (!rst_n)       seen_q <= 1'b0;
        else if (!arm)    seen_q <= 1'b0;
        else if (up_in)   seen_q <= 1'b1;
    end

    // Combined view of history and the present cycle.
    always_comb seen = seen_q || (arm && up_in);

    // Once seen within a window, it stays seen until the window ends (R4).
    assert_seen_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && seen) |=> (!arm || seen));

    // A disarmed capture reports nothing (R6).
    assert_disarmed_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> (arm || !seen));

endmodule

// File: rtl/bsel_fsm.sv
// Sequencer for the band search: idle, observe at upper-band minimum,
// park at maximum of the chosen band, done with voltage released.
// Assumes: expire inputs are single-cycle and qualified by the matching state.
module bsel_fsm
    import bsel_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic        win_expire,
    input  logic        park_expire,
    input  logic        up_seen,
    output bsel_state_e state,
    output logic        band_sel,
    output logic [1:0]  vforce,
    output logic        done
);
    bsel_state_e state_nx;

    // Next-state selection; enable low always returns to idle.
    always_comb begin
        state_nx = state;
        if (!enable) begin
            state_nx = ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:    state_nx = ST_OBSERVE;
                ST_OBSERVE: if (win_expire)  state_nx = ST_PARK;
                ST_PARK:    if (park_expire) state_nx = ST_DONE;
                ST_DONE:    state_nx = ST_DONE;
                default:    state_nx = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Band bit: upper band at start, decided once at window end, else held.
    always_ff @(posedge clk) begin
        if (!rst_n)
            band_sel <= BAND_HIGH;
        else if (enable && state == ST_IDLE)
            band_sel <= BAND_HIGH;
        else if (enable && state == ST_OBSERVE && win_expire)
            band_sel <= up_seen ? BAND_HIGH : BAND_LOW;
    end

    // Output decode from state.
    always_comb begin
        case (state)
            ST_OBSERVE: vforce = VF_MIN;
            ST_PARK:    vforce = VF_MAX;
            default:    vforce = VF_RELEASE;
        endcase
        done = (state == ST_DONE);
    end

    // Observation always runs on the upper band (R2).
    assert_observe_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OBSERVE) |-> band_sel);

    // Leaving observation goes only to park (R3).
    assert_observe_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OBSERVE && enable) |=> (state == ST_OBSERVE || state == ST_PARK));

endmodule

// File: rtl/vco_band_picker.sv
// Top of the two-band oscillator band selector. Picks the band from a single
// UP observation at the upper-band minimum, parks at the chosen band's
// maximum for PARK_TICKS settle ticks, then reports done.
// Assumes: settle_tick is a one-cycle pulse; win_ticks steady during a window.
module vco_band_picker
    import bsel_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int PARK_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             up_in,
    input  logic             settle_tick,
    input  logic [CNT_W-1:0] win_ticks,
    output logic             band_sel,
    output logic [1:0]       vforce,
    output logic             done
);
    localparam int PARK_W = $clog2(PARK_TICKS + 1);
    localparam logic [PARK_W-1:0] PARK_LIM = PARK_W'(PARK_TICKS);

    bsel_state_e state;
    logic        in_observe;
    logic        in_park;
    logic        win_expire;
    logic        park_expire;
    logic        up_seen;

    // State qualifiers for the helper blocks.
    always_comb begin
        in_observe = (state == ST_OBSERVE);
        in_park    = (state == ST_PARK);
    end

    bsel_tick_window #(.W(CNT_W)) i_win_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (in_observe),
        .tick   (settle_tick),
        .limit  (win_ticks),
        .expire (win_expire)
    );

    bsel_tick_window #(.W(PARK_W)) i_park_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (in_park),
        .tick   (settle_tick),
        .limit  (PARK_LIM),
        .expire (park_expire)
    );

    bsel_up_capture i_up_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (in_observe),
        .up_in (up_in),
        .seen  (up_seen)
    );

    bsel_fsm i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .win_expire  (win_expire),
        .park_expire (park_expire),
        .up_seen     (up_seen),
        .state       (state),
        .band_sel    (band_sel),
        .vforce      (vforce),
        .done        (done)
    );

    // Dropping enable clears done and releases the voltage (R8).
    assert_abort_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!done && vforce == VF_RELEASE));

    // Dropping enable never changes the band bit (R8).
    assert_abort_keeps_band_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(band_sel));

    // Done is only entered from the maximum hold (R7).
    assert_done_after_park_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(vforce) == VF_MAX));

    // Band bit changes only when starting or leaving the minimum hold (R6).
    assert_band_change_point_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(band_sel) |-> ($past(vforce) != VF_MAX && !$past(done)));

    // The reserved voltage code is never produced (R1).
    assert_vforce_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        vforce != 2'b11);

endmodule

// File: tb/test_vco_band_picker.sv
module test_vco_band_picker;
    localparam int CNT_W = 8;
    localparam int PARK_TICKS = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic             up_in = 1'b0;
    logic             settle_tick = 1'b0;
    logic [CNT_W-1:0] win_ticks = '0;
    logic             band_sel;
    logic [1:0]       vforce;
    logic             done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        bit         chk;
        logic       b;
        logic [1:0] v;
        logic       d;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    always #2 clk = ~clk;

    vco_band_picker #(.CNT_W(CNT_W), .PARK_TICKS(PARK_TICKS)) i_vco_band_picker (
        .clk(clk), .rst_n(rst_n), .enable(enable), .up_in(up_in),
        .settle_tick(settle_tick), .win_ticks(win_ticks),
        .band_sel(band_sel), .vforce(vforce), .done(done)
    );

    // Driver: drive inputs at the falling edge, queue the expected outputs
    // seen just after the following rising edge.
    task automatic step(input logic en, input logic up, input logic tk,
                        input bit chk, input logic eb, input logic [1:0] ev,
                        input logic ed, input string tag);
        exp_t e;
        @(negedge clk);
        enable = en; up_in = up; settle_tick = tk;
        e.chk = chk; e.b = eb; e.v = ev; e.d = ed; e.tag = tag;
        exp_q.push_back(e);
        @(posedge clk);
    endtask

    // Monitor: pop and compare one item after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.chk) begin
                    checks++;
                    if (band_sel !== e.b || vforce !== e.v || done !== e.d) begin
                        errors++;
                        $display("FAIL %s: band=%b vforce=%b done=%b expected band=%b vforce=%b done=%b",
                                 e.tag, band_sel, vforce, done, e.b, e.v, e.d);
                    end
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state, both under reset and after release.
        win_ticks = 8'd3;
        step(0, 0, 0, 0, 1, 2'b00, 0, "R1");
        step(0, 0, 0, 1, 1, 2'b00, 0, "R1");
        @(negedge clk); rst_n = 1'b1;
        step(0, 0, 0, 1, 1, 2'b00, 0, "R1");

        // Scenario A: window of 3, UP mid-window -> upper band.
        step(1, 0, 0, 1, 1, 2'b01, 0, "R2");
        step(1, 0, 1, 1, 1, 2'b01, 0, "R3");
        step(1, 1, 0, 1, 1, 2'b01, 0, "R3");
        step(1, 0, 1, 1, 1, 2'b01, 0, "R3");
        step(1, 0, 1, 1, 1, 2'b10, 0, "R4");
        step(1, 0, 1, 1, 1, 2'b10, 0, "R7");
        step(1, 0, 1, 1, 1, 2'b00, 1, "R7");
        step(1, 0, 0, 1, 1, 2'b00, 1, "R7");
        step(0, 0, 0, 1, 1, 2'b00, 0, "R8");

        // Scenario B: idle UP/ticks ignored, window of 2 without UP -> lower band.
        win_ticks = 8'd2;
        step(0, 1, 1, 1, 1, 2'b00, 0, "R6");
        step(1, 0, 0, 1, 1, 2'b01, 0, "R2");
        step(1, 0, 1, 1, 1, 2'b01, 0, "R3");
        step(1, 0, 1, 1, 0, 2'b10, 0, "R5");
        step(1, 1, 1, 1, 0, 2'b10, 0, "R6");
        step(1, 1, 1, 1, 0, 2'b00, 1, "R7");
        step(1, 1, 0, 1, 0, 2'b00, 1, "R6");
        step(0, 0, 0, 1, 0, 2'b00, 0, "R8");

        // Scenario C: restart, UP only on final-tick cycle, abort during park.
        step(1, 0, 0, 1, 1, 2'b01, 0, "R8");
        step(1, 0, 1, 1, 1, 2'b01, 0, "R3");
        step(1, 1, 1, 1, 1, 2'b10, 0, "R4");
        step(0, 0, 0, 1, 1, 2'b00, 0, "R8");

        // Scenario D: zero window acts as one tick.
        win_ticks = 8'd0;
        step(1, 0, 0, 1, 1, 2'b01, 0, "R2");
        step(1, 0, 0, 1, 1, 2'b01, 0, "R3");
        step(1, 0, 1, 1, 0, 2'b10, 0, "R3");
        step(0, 0, 0, 1, 0, 2'b00, 0, "R8");

        // Scenario E: abort during observation keeps band bit (set high on start).
        win_ticks = 8'd3;
        step(1, 0, 0, 1, 1, 2'b01, 0, "R2");
        step(0, 1, 0, 1, 1, 2'b00, 0, "R8");

        // Scenario F: idle ticks do not count toward the window.
        step(0, 0, 1, 1, 1, 2'b00, 0, "R9");
        step(0, 0, 1, 1, 1, 2'b00, 0, "R9");
        step(0, 0, 1, 1, 1, 2'b00, 0, "R9");
        step(1, 0, 1, 1, 1, 2'b01, 0, "R9");
        step(1, 0, 1, 1, 1, 2'b01, 0, "R9");
        step(1, 0, 1, 1, 1, 2'b01, 0, "R9");
        step(1, 0, 1, 1, 0, 2'b10, 0, "R9");
        step(1, 0, 0, 1, 0, 2'b10, 0, "R7");
        step(1, 0, 1, 1, 0, 2'b10, 0, "R7");
        step(1, 1, 1, 1, 0, 2'b00, 1, "R7");

        step(0, 0, 0, 0, 0, 2'b00, 0, "end");
        @(posedge clk);
        #2;
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule